// File: doc/BRIEF.md
# Three-Byte Indirect Register Access Controller

This block gives a host with a small byte-wide register bus a way to reach a larger internal memory space through one access register. The host writes three bytes in a row to that register: first an operation byte (direction bit plus a two-bit operation code), then an address byte, then a data byte. The third byte launches the operation on an internal memory request port. While the operation is in flight the block reports itself busy and refuses further bytes.

A status register shows how far the host is into a sequence and whether an operation is still running. A command bit throws away a half-finished sequence. An interrupt status register collects a completion event from the sequencer and a set of external completion events. A mask register hides selected bits from both the interrupt pin and the status read without losing them.

The memory request port is valid/ready. The block holds `mem_req_valid` and every request field stable until it sees `mem_req_ready` in the same cycle. Write operations finish on that handshake. Read operations then wait for a single-cycle `mem_rsp_valid` pulse, which the block always accepts. The host bus uses plain single-cycle strobes. `host_rdata` is combinational from the current address, and the side effects of a read take place at the clock edge that ends the strobe.

Top module: `ind_acc_ctrl`

## Requirements
- R1: After reset, status reads 01h, and the mode register, the interrupt status register and the mask all read or act as 00h. Address map: 0 = mode (read/write); 1 = status on read, command on write; 2 = interrupt status on read, mask on write; 3 = access register.
- R2: Status holds busy in bit 2, a nonzero-progress (incomplete) flag in bit 1, not-busy in bit 0, and the count of bytes accepted so far in the current sequence in bits 4:3. After one byte it reads 0Bh, and after two bytes it reads 13h.
- R3: The third byte written to the access register sets busy and raises `mem_req_valid`. The request carries write = byte0 bit 7, op = byte0 bits 1:0, address = byte1 and data = byte2. Status reads 04h while the request is pending.
- R4: A write operation completes at the request handshake. A read operation completes on `mem_rsp_valid`, and its response byte can then be read from the access register. Request fields stay stable while the request is stalled.
- R5: While busy, writes to the access register are ignored and do not advance the byte count. Reads of the access register return the status byte.
- R6: Writing the command register with bit 0 set and busy clear returns the byte count to zero, and a full sequence can then start. A command write with bit 0 clear changes nothing.
- R7: A read of the interrupt status register returns the unmasked pending bits and clears exactly those bits. An event that arrives in the same cycle as the read stays pending.
- R8: A masked pending bit is hidden from the interrupt status read and from `irq_o`, and a read does not clear it. Clearing the mask bit makes it visible at once.
- R9: `irq_o` is high exactly when at least one unmasked bit is pending.
- R10: Interrupt bit 0 records completion of an indirect operation. Bit k+1 records a pulse on `evt_i[k]`.
- R11: The mode register stores any byte written to address 0 and drives it on `mode_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 2 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_wr | input | 1 | Host write strobe, one cycle per transfer |
| host_rd | input | 1 | Host read strobe, one cycle per transfer |
| host_rdata | output | 8 | Read data for the current address |
| mode_o | output | 8 | Mode register contents |
| evt_i | input | NUM_EVT | External completion event pulses |
| irq_o | output | 1 | Interrupt request |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_wr | output | 1 | Request direction, 1 = write |
| mem_req_op | output | 2 | Request operation code |
| mem_req_addr | output | 8 | Request address |
| mem_req_data | output | 8 | Request write data |
| mem_rsp_valid | input | 1 | Read response valid pulse |
| mem_rsp_data | input | 8 | Read response byte |

## Verification
A miscounted sequence position shows up on the very next status read as a wrong value in bits 4:3. A wrong count also shifts which byte lands in the address or data field, so the bench sees a mismatched request field the cycle the request is raised, and later a wrong read-back byte. A busy flag that is stuck high or cleared too early appears either as a status read that never returns to 01h, or as a response byte lost before `mem_rsp_valid`. A pending bit that is wrongly cleared or leaks through the mask is visible on `irq_o` in the cycle after the event, and on the next interrupt status read.

// File: rtl/iac_pkg.sv
package iac_pkg;
  localparam int BYTE_W  = 8;
  localparam int HOST_AW = 2;
  localparam int OP_W    = 2;
  localparam int CNT_W   = 2;

  localparam logic [HOST_AW-1:0] A_MODE = 2'd0;
  localparam logic [HOST_AW-1:0] A_STAT = 2'd1;
  localparam logic [HOST_AW-1:0] A_INT  = 2'd2;
  localparam logic [HOST_AW-1:0] A_ACC  = 2'd3;

  localparam int OPB_WR = 7;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_REQ  = 2'd1,
    S_WAIT = 2'd2
  } seq_st_e;
endpackage

// File: rtl/iac_seq.sv
module iac_seq
  import iac_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                acc_wr,
  input  logic [BYTE_W-1:0]   wdata,
  input  logic                abort,
  output logic [CNT_W-1:0]    cnt,
  output logic                busy,
  output logic                done,
  output logic [BYTE_W-1:0]   result,
  output logic                mem_req_valid,
  input  logic                mem_req_ready,
  output logic                mem_req_wr,
  output logic [OP_W-1:0]     mem_req_op,
  output logic [BYTE_W-1:0]   mem_req_addr,
  output logic [BYTE_W-1:0]   mem_req_data,
  input  logic                mem_rsp_valid,
  input  logic [BYTE_W-1:0]   mem_rsp_data
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(2);

  seq_st_e            st;
  logic [BYTE_W-1:0]  op_q, adr_q, dat_q, res_q;
  logic [CNT_W-1:0]   cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cnt_q <= '0;
      op_q  <= '0;
      adr_q <= '0;
      dat_q <= '0;
      res_q <= '0;
    end else begin
      unique case (st)
        S_IDLE: begin
          if (acc_wr) begin
            if (cnt_q == '0) begin
              op_q  <= wdata;
              cnt_q <= cnt_q + 1'b1;
            end else if (cnt_q != LAST) begin
              adr_q <= wdata;
              cnt_q <= cnt_q + 1'b1;
            end else begin
              dat_q <= wdata;
              cnt_q <= '0;
              st    <= S_REQ;
            end
          end else if (abort) begin
            cnt_q <= '0;
          end
        end
        S_REQ: begin
          if (mem_req_ready) st <= op_q[OPB_WR] ? S_IDLE : S_WAIT;
        end
        S_WAIT: begin
          if (mem_rsp_valid) begin
            res_q <= mem_rsp_data;
            st    <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    busy          = (st != S_IDLE);
    mem_req_valid = (st == S_REQ);
    done          = ((st == S_REQ) && mem_req_ready && op_q[OPB_WR]) ||
                    ((st == S_WAIT) && mem_rsp_valid);
  end

  assign cnt          = cnt_q;
  assign result       = res_q;
  assign mem_req_wr   = op_q[OPB_WR];
  assign mem_req_op   = op_q[OP_W-1:0];
  assign mem_req_addr = adr_q;
  assign mem_req_data = dat_q;
endmodule

// File: rtl/iac_irq.sv
module iac_irq #(
  parameter int N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] set_i,
  input  logic             mask_wr,
  input  logic [N_SRC-1:0] mask_wdata,
  input  logic             rd_clr,
  output logic [N_SRC-1:0] pend_vis,
  output logic             irq
);
  logic [N_SRC-1:0] pend_q, mask_q;

  assign pend_vis = pend_q & ~mask_q;
  assign irq      = |pend_vis;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pend_q[i] <= 1'b0;
        mask_q[i] <= 1'b0;
      end else begin
        if (set_i[i])                   pend_q[i] <= 1'b1;
        else if (rd_clr && pend_vis[i]) pend_q[i] <= 1'b0;
        if (mask_wr)                    mask_q[i] <= mask_wdata[i];
      end
    end
  end
endmodule

// File: rtl/iac_regs.sv
module iac_regs
  import iac_pkg::*;
#(
  parameter int N_SRC = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [HOST_AW-1:0]  host_addr,
  input  logic [BYTE_W-1:0]   host_wdata,
  input  logic                host_wr,
  input  logic                host_rd,
  input  logic                busy,
  input  logic [CNT_W-1:0]    cnt,
  input  logic [N_SRC-1:0]    pend_vis,
  input  logic [BYTE_W-1:0]   result,
  output logic [BYTE_W-1:0]   mode,
  output logic                acc_wr,
  output logic                abort,
  output logic                mask_wr,
  output logic                int_rd,
  output logic [BYTE_W-1:0]   rdata
);
  logic [BYTE_W-1:0] mode_q, status;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              mode_q <= '0;
    else if (host_wr && host_addr == A_MODE) mode_q <= host_wdata;
  end

  always_comb begin
    status        = '0;
    status[0]     = ~busy;
    status[1]     = (cnt != '0);
    status[2]     = busy;
    status[4:3]   = cnt;
    acc_wr        = host_wr && (host_addr == A_ACC) && !busy;
    abort         = host_wr && (host_addr == A_STAT) && host_wdata[0] && !busy;
    mask_wr       = host_wr && (host_addr == A_INT);
    int_rd        = host_rd && (host_addr == A_INT);
    unique case (host_addr)
      A_MODE:  rdata = mode_q;
      A_STAT:  rdata = status;
      A_INT:   rdata = BYTE_W'(pend_vis);
      default: rdata = busy ? status : result;
    endcase
  end

  assign mode = mode_q;
endmodule

// File: rtl/ind_acc_ctrl.sv
module ind_acc_ctrl
  import iac_pkg::*;
#(
  parameter int NUM_EVT = 7
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [HOST_AW-1:0]         host_addr,
  input  logic [BYTE_W-1:0]          host_wdata,
  input  logic                       host_wr,
  input  logic                       host_rd,
  output logic [BYTE_W-1:0]          host_rdata,
  output logic [BYTE_W-1:0]          mode_o,
  input  logic [NUM_EVT-1:0]         evt_i,
  output logic                       irq_o,
  output logic                       mem_req_valid,
  input  logic                       mem_req_ready,
  output logic                       mem_req_wr,
  output logic [OP_W-1:0]            mem_req_op,
  output logic [BYTE_W-1:0]          mem_req_addr,
  output logic [BYTE_W-1:0]          mem_req_data,
  input  logic                       mem_rsp_valid,
  input  logic [BYTE_W-1:0]          mem_rsp_data
);
  localparam int N_SRC = NUM_EVT + 1;

  logic               acc_wr, abort, mask_wr, int_rd, busy, done;
  logic [CNT_W-1:0]   cnt;
  logic [BYTE_W-1:0]  result;
  logic [N_SRC-1:0]   pend_vis;

  iac_seq u_seq (
    .clk, .rst_n, .acc_wr, .wdata(host_wdata), .abort,
    .cnt, .busy, .done, .result,
    .mem_req_valid, .mem_req_ready, .mem_req_wr, .mem_req_op,
    .mem_req_addr, .mem_req_data, .mem_rsp_valid, .mem_rsp_data
  );

  iac_irq #(.N_SRC(N_SRC)) u_irq (
    .clk, .rst_n,
    .set_i({evt_i, done}),
    .mask_wr, .mask_wdata(host_wdata[N_SRC-1:0]),
    .rd_clr(int_rd), .pend_vis, .irq(irq_o)
  );

  iac_regs #(.N_SRC(N_SRC)) u_regs (
    .clk, .rst_n, .host_addr, .host_wdata, .host_wr, .host_rd,
    .busy, .cnt, .pend_vis, .result,
    .mode(mode_o), .acc_wr, .abort, .mask_wr, .int_rd,
    .rdata(host_rdata)
  );
endmodule

// File: rtl/iac_chk.sv
module iac_chk
  import iac_pkg::*;
#(
  parameter int NUM_EVT = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic [HOST_AW-1:0] host_addr,
  input logic [BYTE_W-1:0]  host_wdata,
  input logic               host_wr,
  input logic               host_rd,
  input logic [NUM_EVT-1:0] evt_i,
  input logic               irq_o,
  input logic               busy,
  input logic               done,
  input logic [CNT_W-1:0]   cnt,
  input logic [NUM_EVT:0]   pend_vis,
  input logic               mem_req_valid,
  input logic               mem_req_ready,
  input logic [BYTE_W-1:0]  mem_req_addr,
  input logic [BYTE_W-1:0]  mem_req_data
);
  p_incomplete_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && host_wr && host_addr == A_ACC && cnt != 2'd2) |=> (cnt != 2'd0));

  p_start_on_third_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(host_wr && host_addr == A_ACC && cnt == 2'd2));

  p_req_needs_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> busy);

  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_data)));

  p_busy_ignores_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && host_wr && host_addr == A_ACC) |=> (cnt == 2'd0));

  p_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == A_STAT && host_wdata[0] && !busy) |=> (cnt == 2'd0));

  p_int_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr == A_INT && !host_wr && evt_i == '0 && !done) |=>
      (pend_vis == '0));

  p_irq_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(evt_i != '0 || done || host_wr));
endmodule

bind ind_acc_ctrl iac_chk #(.NUM_EVT(NUM_EVT)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
  .host_wr(host_wr), .host_rd(host_rd), .evt_i(evt_i), .irq_o(irq_o),
  .busy(busy), .done(done), .cnt(cnt), .pend_vis(pend_vis),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .mem_req_data(mem_req_data)
);

// File: tb/ind_acc_ctrl_bench.sv
module ind_acc_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] haddr = '0;
  logic [7:0] hwdata = '0;
  logic       hwr = 1'b0, hrd = 1'b0;
  logic [7:0] hrdata, mode;
  logic [6:0] evt = '0;
  logic       irq;
  logic       req_valid, req_wr;
  logic       req_ready = 1'b1;
  logic [1:0] req_op;
  logic [7:0] req_addr, req_data;
  logic       rsp_valid = 1'b0;
  logic [7:0] rsp_data = '0;

  int checks = 0, errors = 0;
  logic [7:0] mem [256];
  int         cd = 0;
  logic [7:0] raddr = '0;
  logic [1:0] last_op = '0;
  logic       last_wr = 1'b0;

  always #10 clk = ~clk;

  ind_acc_ctrl u_ind_acc_ctrl (
    .clk, .rst_n, .host_addr(haddr), .host_wdata(hwdata), .host_wr(hwr),
    .host_rd(hrd), .host_rdata(hrdata), .mode_o(mode), .evt_i(evt),
    .irq_o(irq), .mem_req_valid(req_valid), .mem_req_ready(req_ready),
    .mem_req_wr(req_wr), .mem_req_op(req_op), .mem_req_addr(req_addr),
    .mem_req_data(req_data), .mem_rsp_valid(rsp_valid), .mem_rsp_data(rsp_data)
  );

  // memory model: accepts requests, answers reads two cycles after handshake
  always @(posedge clk) begin
    rsp_valid <= 1'b0;
    if (cd != 0) begin
      cd <= cd - 1;
      if (cd == 1) begin
        rsp_valid <= 1'b1;
        rsp_data  <= mem[raddr];
      end
    end
    if (req_valid && req_ready) begin
      last_op <= req_op;
      last_wr <= req_wr;
      if (req_wr) mem[req_addr] <= req_data;
      else begin
        cd    <= 2;
        raddr <= req_addr;
      end
    end
  end

  task automatic chk(string r, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic bus_wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk);
    haddr = a; hwdata = d; hwr = 1'b1;
    @(negedge clk);
    hwr = 1'b0;
  endtask

  task automatic bus_rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    haddr = a; hrd = 1'b1;
    #1 d = hrdata;
    @(negedge clk);
    hrd = 1'b0;
  endtask

  task automatic do_op(logic w, logic [1:0] op, logic [7:0] a, logic [7:0] d);
    bus_wr(2'd3, {w, 5'b0, op});
    bus_wr(2'd3, a);
    bus_wr(2'd3, d);
  endtask

  task automatic wait_idle(output int n);
    logic [7:0] s;
    n = 0;
    do begin
      bus_rd(2'd1, s);
      n++;
    end while (s[2] && n < 40);
  endtask

  task automatic pulse_evt(logic [6:0] e);
    @(negedge clk);
    evt = e;
    @(negedge clk);
    evt = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    bus_rd(2'd1, v); chk("R1 status", v, 8'h01);
    bus_rd(2'd0, v); chk("R1 mode", v, 8'h00);
    bus_rd(2'd2, v); chk("R1 int status", v, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);
    pulse_evt(7'h01);
    chk("R1 mask clear at reset, irq", {7'b0, irq}, 8'h01);
    bus_rd(2'd2, v); chk("R10 event bit1", v, 8'h02);

    // R11 mode register
    bus_wr(2'd0, 8'hA5);
    bus_rd(2'd0, v); chk("R11 mode read", v, 8'hA5);
    chk("R11 mode_o", mode, 8'hA5);

    // R2 / R6 progress and abort
    bus_wr(2'd3, 8'h80);
    bus_rd(2'd1, v); chk("R2 one byte", v, 8'h0B);
    bus_wr(2'd1, 8'h00);
    bus_rd(2'd1, v); chk("R6 no-abort cmd", v, 8'h0B);
    bus_wr(2'd3, 8'h11);
    bus_rd(2'd1, v); chk("R2 two bytes", v, 8'h13);
    bus_wr(2'd1, 8'h01);
    bus_rd(2'd1, v); chk("R6 abort", v, 8'h01);
    chk("R6 no request", {7'b0, req_valid}, 8'h00);

    // sweep: write then read back across addresses and op codes
    for (int i = 0; i < 16; i++) begin
      logic [7:0] a, d;
      logic [1:0] op;
      a = 8'(i * 17);
      d = 8'(i * 29 + 7);
      op = 2'(i % 4);
      do_op(1'b1, op, a, d);
      bus_rd(2'd1, v); chk("R4 write done on handshake", v, 8'h01);
      chk("R3 write op field", {5'b0, last_wr, last_op}, {5'b0, 1'b1, op});
      bus_rd(2'd2, v); chk("R10 completion bit0", v, 8'h01);
      do_op(1'b0, ~op, a, 8'h00);
      bus_rd(2'd1, v); chk("R3 busy after third byte", v, 8'h04);
      wait_idle(n);
      chk("R4 read completes", {7'b0, n < 10}, 8'h01);
      chk("R3 read op field", {5'b0, last_wr, last_op}, {5'b0, 1'b0, ~op});
      bus_rd(2'd3, v); chk("R4 read-back", v, d);
      bus_rd(2'd2, v); chk("R7 clear on read", v, 8'h01);
    end

    // R4 / R5 back-pressure and busy behaviour
    @(negedge clk); req_ready = 1'b0;
    do_op(1'b1, 2'd2, 8'h42, 8'h99);
    chk("R3 req valid", {7'b0, req_valid}, 8'h01);
    chk("R3 req addr", req_addr, 8'h42);
    chk("R3 req data", req_data, 8'h99);
    chk("R3 req op/wr", {5'b0, req_wr, req_op}, 8'h06);
    bus_wr(2'd3, 8'hFF);
    bus_rd(2'd3, v); chk("R5 access reads status", v, 8'h04);
    bus_rd(2'd1, v); chk("R5 write ignored", v, 8'h04);
    repeat (3) @(negedge clk);
    chk("R4 stalled addr stable", req_addr, 8'h42);
    chk("R4 stalled data stable", req_data, 8'h99);
    req_ready = 1'b1;
    wait_idle(n);
    chk("R4 released", {7'b0, req_valid}, 8'h00);
    bus_rd(2'd2, v);
    do_op(1'b0, 2'd0, 8'h42, 8'h00);
    wait_idle(n);
    bus_rd(2'd3, v); chk("R4 stalled write landed", v, 8'h99);
    bus_rd(2'd2, v);

    // R8 / R9 masking
    bus_wr(2'd2, 8'h02);
    pulse_evt(7'h01);
    chk("R8 masked irq low", {7'b0, irq}, 8'h00);
    bus_rd(2'd2, v); chk("R8 masked hidden", v, 8'h00);
    bus_wr(2'd2, 8'h00);
    chk("R8 unmask irq high", {7'b0, irq}, 8'h01);
    bus_rd(2'd2, v); chk("R8 kept while masked", v, 8'h02);
    bus_rd(2'd2, v); chk("R7 cleared", v, 8'h00);
    chk("R9 irq low when empty", {7'b0, irq}, 8'h00);

    // R7 event in the same cycle as the read
    @(negedge clk);
    haddr = 2'd2; hrd = 1'b1; evt = 7'h04;
    #1 chk("R7 read before event", hrdata, 8'h00);
    @(negedge clk);
    hrd = 1'b0; evt = '0;
    chk("R9 irq from event", {7'b0, irq}, 8'h01);
    bus_rd(2'd2, v); chk("R7 concurrent event kept", v, 8'h08);

    pulse_evt(7'h41);
    bus_rd(2'd2, v); chk("R10 two events", v, 8'h82);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule